// File: doc/BRIEF.md
# Deductive Single Stuck-At Fault Diagnoser

The block diagnoses a small fixed gate-level netlist, a one-bit full adder made only of two-input AND gates and inverters, under the single stuck-at fault model. A faulty gate drives a constant 0 or a constant 1 whatever its inputs are. Every internal signal carries two things: its fault-free logic value, and a bitmask of every single fault that would turn that signal to the opposite value. An empty mask means that no single fault can change the signal. Each gate is treated as an ideal gate followed by a fault buffer. Only the buffer can fail, so the fault universe is twice the gate count (44 faults for 22 gates).

A one-cycle `start` pulse captures the primary input vector and the output vector observed on the real circuit. The block then evaluates the netlist one logic level per clock cycle. An ideal inverter complements the value and passes the mask through. An ideal AND gate forms the union, intersection or difference of its input masks, depending on its input values. Each fault buffer adds its own flipping fault to the mask. At the end the block compares the observed outputs with the fault-free outputs. The diagnosis is the intersection of the masks of the outputs that mismatch, minus the union of the masks of the outputs that match. The block returns the fault-free output, the diagnosis mask, a no-error flag, and a one-cycle `done` pulse.

Netlist, gate g in order (signals: a=pi[0], b=pi[1], c=pi[2], Gk = output of gate k):

| g | gate |
|---|------|
| 0 | NOT a |
| 1 | NOT b |
| 2 | AND(a, G1) |
| 3 | AND(G0, b) |
| 4 | NOT G2 |
| 5 | NOT G3 |
| 6 | AND(G4, G5) |
| 7 | NOT G6 (half sum p) |
| 8 | NOT G7 |
| 9 | NOT c |
| 10 | AND(G7, G9) |
| 11 | AND(G8, c) |
| 12 | NOT G10 |
| 13 | NOT G11 |
| 14 | AND(G12, G13) |
| 15 | NOT G14 (sum) |
| 16 | AND(a, b) |
| 17 | AND(G7, c) |
| 18 | NOT G16 |
| 19 | NOT G17 |
| 20 | AND(G18, G19) |
| 21 | NOT G20 (carry) |

Top module: `stuck_fault_diagnoser`

## Requirements
- R1: After a synchronous active-low reset, `done`, `no_error`, `good_out` and `diag_mask` are all zero.
- R2: `good_out` is the fault-free netlist result: bit 0 is the sum and bit 1 is the carry of pi[0]+pi[1]+pi[2].
- R3: Bit 2g of a fault mask stands for gate g (numbered as in the netlist table) stuck-at-0, and bit 2g+1 stands for gate g stuck-at-1. A gate's output mask holds the fault of that gate that opposes its fault-free value, and never the other one.
- R4: When the observed vector `obs_vec` (bit 0 sum, bit 1 carry) differs from `good_out`, `diag_mask` has bit f set exactly when injecting single fault f alone makes the netlist produce `obs_vec`.
- R5: When `obs_vec` equals the fault-free output, `no_error` is 1 and `diag_mask` is zero. Otherwise `no_error` is 0.
- R6: An observed mismatch that no single fault can produce gives an all-zero `diag_mask` with `no_error` at 0.
- R7: `done` is high for exactly one cycle, on the 11th rising edge after the edge that samples `start` (10 logic levels plus one result cycle).
- R8: A `start` pulse during a run is ignored, and the results keep their values between `done` pulses.
- R9: `diag_mask` never sets both stuck-at faults of the same gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a diagnosis run |
| pi_vec | input | 3 | Primary inputs a, b, c (bits 0..2) |
| obs_vec | input | 2 | Observed outputs: bit 0 sum, bit 1 carry |
| done | output | 1 | One-cycle pulse when the results are valid |
| good_out | output | 2 | Fault-free outputs: bit 0 sum, bit 1 carry |
| diag_mask | output | 44 | Single faults consistent with the observation |
| no_error | output | 1 | The observation matches the fault-free output |

## Verification
All eight input vectors are paired with all four observed vectors. The pairing that equals the fault-free output tests the no-error path. The single-bit and double-bit mismatches separate faults that flip only the sum, only the carry, or both. Observations that no fault can produce must give an empty mask. A bench model of the netlist with fault injection enumerates, for every one of the 44 faults, whether that fault reproduces the observation, and the diagnosis mask must match that list exactly. One extra run pulses `start` with different operands in the middle of a run, to show that the pulse leaves the result and the latency unchanged.

// File: rtl/fdiag_pkg.sv
// Package for the single stuck-at diagnoser: netlist description, derived
// sizes and shared types. Assumes the netlist is listed in topological order
// (every gate's sources have lower signal indices).
package fdiag_pkg;

    localparam int NUM_PI   = 3;
    localparam int NUM_GATE = 22;
    localparam int NUM_PO   = 2;
    localparam int NUM_SIG  = NUM_PI + NUM_GATE;
    localparam int FAULT_W  = 2 * NUM_GATE;

    typedef enum logic {GK_AND = 1'b0, GK_NOT = 1'b1} gate_kind_e;

    typedef struct packed {
        gate_kind_e kind;
        logic [7:0] src_a;
        logic [7:0] src_b;
    } gate_desc_t;

    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_PROP = 2'd1, ST_FIN = 2'd2} seq_state_e;

    // Signal index of the output of gate g.
    function automatic int gs(int g);
        return NUM_PI + g;
    endfunction

    // Netlist: full adder from AND and NOT; signals 0..2 are a, b, c.
    function automatic gate_desc_t gate_desc(int g);
        gate_desc_t d;
        d.kind  = GK_NOT;
        d.src_a = 8'd0;
        d.src_b = 8'd0;
        case (g)
            0:  begin d.kind = GK_NOT; d.src_a = 8'd0;         d.src_b = 8'd0;         end
            1:  begin d.kind = GK_NOT; d.src_a = 8'd1;         d.src_b = 8'd1;         end
            2:  begin d.kind = GK_AND; d.src_a = 8'd0;         d.src_b = 8'(gs(1));    end
            3:  begin d.kind = GK_AND; d.src_a = 8'(gs(0));    d.src_b = 8'd1;         end
            4:  begin d.kind = GK_NOT; d.src_a = 8'(gs(2));    d.src_b = 8'(gs(2));    end
            5:  begin d.kind = GK_NOT; d.src_a = 8'(gs(3));    d.src_b = 8'(gs(3));    end
            6:  begin d.kind = GK_AND; d.src_a = 8'(gs(4));    d.src_b = 8'(gs(5));    end
            7:  begin d.kind = GK_NOT; d.src_a = 8'(gs(6));    d.src_b = 8'(gs(6));    end
            8:  begin d.kind = GK_NOT; d.src_a = 8'(gs(7));    d.src_b = 8'(gs(7));    end
            9:  begin d.kind = GK_NOT; d.src_a = 8'd2;         d.src_b = 8'd2;         end
            10: begin d.kind = GK_AND; d.src_a = 8'(gs(7));    d.src_b = 8'(gs(9));    end
            11: begin d.kind = GK_AND; d.src_a = 8'(gs(8));    d.src_b = 8'd2;         end
            12: begin d.kind = GK_NOT; d.src_a = 8'(gs(10));   d.src_b = 8'(gs(10));   end
            13: begin d.kind = GK_NOT; d.src_a = 8'(gs(11));   d.src_b = 8'(gs(11));   end
            14: begin d.kind = GK_AND; d.src_a = 8'(gs(12));   d.src_b = 8'(gs(13));   end
            15: begin d.kind = GK_NOT; d.src_a = 8'(gs(14));   d.src_b = 8'(gs(14));   end
            16: begin d.kind = GK_AND; d.src_a = 8'd0;         d.src_b = 8'd1;         end
            17: begin d.kind = GK_AND; d.src_a = 8'(gs(7));    d.src_b = 8'd2;         end
            18: begin d.kind = GK_NOT; d.src_a = 8'(gs(16));   d.src_b = 8'(gs(16));   end
            19: begin d.kind = GK_NOT; d.src_a = 8'(gs(17));   d.src_b = 8'(gs(17));   end
            20: begin d.kind = GK_AND; d.src_a = 8'(gs(18));   d.src_b = 8'(gs(19));   end
            21: begin d.kind = GK_NOT; d.src_a = 8'(gs(20));   d.src_b = 8'(gs(20));   end
            default: ;
        endcase
        return d;
    endfunction

    // Signal index driving primary output k (0 = sum, 1 = carry).
    function automatic int po_sig(int k);
        return (k == 0) ? gs(15) : gs(21);
    endfunction

    // Logic level of gate g: one more than the deepest of its sources.
    function automatic int gate_level(int g);
        int lv [NUM_GATE];
        for (int k = 0; k < NUM_GATE; k++) begin
            gate_desc_t d;
            int la;
            int lb;
            d  = gate_desc(k);
            la = (int'(d.src_a) < NUM_PI) ? 0 : lv[int'(d.src_a) - NUM_PI];
            lb = (int'(d.src_b) < NUM_PI) ? 0 : lv[int'(d.src_b) - NUM_PI];
            lv[k] = ((la > lb) ? la : lb) + 1;
        end
        return lv[g];
    endfunction

    // Deepest level in the netlist.
    function automatic int max_depth();
        int m;
        m = 0;
        for (int k = 0; k < NUM_GATE; k++)
            if (gate_level(k) > m) m = gate_level(k);
        return m;
    endfunction

    localparam int DEPTH = max_depth();
    localparam int LVL_W = $clog2(DEPTH + 1);

endpackage

// File: rtl/fdiag_sequencer.sv
// Run controller: captures a start pulse, steps the level counter through
// 1..DEPTH (one logic level per cycle), then raises fin for one cycle.
// Assumes start is ignored whenever a run is in progress.
module fdiag_sequencer
    import fdiag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             capture,
    output logic             in_prop,
    output logic [LVL_W-1:0] eval_lvl,
    output logic             fin
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(DEPTH);

    seq_state_e       state;
    logic [LVL_W-1:0] lvl;

    // Decode the current state into strobes for the datapath.
    always_comb begin
        capture  = (state == ST_IDLE) && start;
        in_prop  = (state == ST_PROP);
        fin      = (state == ST_FIN);
        eval_lvl = lvl;
    end

    // State and level counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lvl   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_PROP;
                    lvl   <= LVL_W'(1);
                end
                ST_PROP: if (lvl == LAST_LVL) begin
                    state <= ST_FIN;
                end else begin
                    lvl <= lvl + LVL_W'(1);
                end
                default: begin
                    state <= ST_IDLE;
                    lvl   <= '0;
                end
            endcase
        end
    end

    // R7: while propagating, the level stays within 1..DEPTH.
    p_level_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_prop |-> (lvl >= LVL_W'(1) && lvl <= LAST_LVL));

    // R8: a start during propagation does not reload the counter.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prop && start && lvl != LAST_LVL) |=> (lvl == $past(lvl) + LVL_W'(1)));

endmodule

// File: rtl/fdiag_gate_cell.sv
// One netlist gate: an ideal AND or NOT that combines the source fault masks,
// followed by the fault buffer that adds this gate's own flipping fault.
// The result is registered when the sequencer reaches this gate's level.
// Assumes the source registers are already final at that level.
module fdiag_gate_cell
    import fdiag_pkg::*;
#(
    parameter int GATE_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_prop,
    input  logic [LVL_W-1:0]   eval_lvl,
    input  logic               a_val,
    input  logic [FAULT_W-1:0] a_mask,
    input  logic               b_val,
    input  logic [FAULT_W-1:0] b_mask,
    output logic               out_val,
    output logic [FAULT_W-1:0] out_mask
);

    localparam gate_kind_e       KIND    = gate_desc(GATE_IDX).kind;
    localparam logic [LVL_W-1:0] MY_LVL  = LVL_W'(gate_level(GATE_IDX));
    localparam int               BIT_SA0 = 2 * GATE_IDX;
    localparam int               BIT_SA1 = BIT_SA0 + 1;
    localparam logic [FAULT_W-1:0] SA0_HOT = FAULT_W'(1) << BIT_SA0;
    localparam logic [FAULT_W-1:0] SA1_HOT = FAULT_W'(1) << BIT_SA1;

    logic               ideal_val;
    logic [FAULT_W-1:0] ideal_mask;
    logic [FAULT_W-1:0] buf_mask;
    logic               step;

    // Ideal gate: value and the set of faults that would flip it.
    always_comb begin
        if (KIND == GK_NOT) begin
            ideal_val  = ~a_val;
            ideal_mask = a_mask;
        end else begin
            ideal_val = a_val & b_val;
            case ({a_val, b_val})
                2'b11:   ideal_mask = a_mask | b_mask;
                2'b00:   ideal_mask = a_mask & b_mask;
                2'b01:   ideal_mask = a_mask & ~b_mask;
                default: ideal_mask = b_mask & ~a_mask;
            endcase
        end
    end

    // Fault buffer: add the stuck-at fault opposite to the fault-free value.
    always_comb begin
        buf_mask = ideal_mask | (ideal_val ? SA0_HOT : SA1_HOT);
        step     = in_prop && (eval_lvl == MY_LVL);
    end

    // Register the gate result at its own level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_val  <= 1'b0;
            out_mask <= '0;
        end else if (step) begin
            out_val  <= ideal_val;
            out_mask <= buf_mask;
        end
    end

    // R3: after evaluation, only the opposing fault of this gate is listed.
    p_own_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (out_val ? (out_mask[BIT_SA0] && !out_mask[BIT_SA1])
                          : (out_mask[BIT_SA1] && !out_mask[BIT_SA0])));

endmodule

// File: rtl/fdiag_reduce.sv
// Diagnosis reduction: intersects the masks of mismatching outputs and
// removes the union of the masks of matching outputs. Assumes the
// output-signal registers hold final values when the result is taken.
module fdiag_reduce
    import fdiag_pkg::*;
(
    input  logic [NUM_PO-1:0]  po_val,
    input  logic [FAULT_W-1:0] po_mask [NUM_PO],
    input  logic [NUM_PO-1:0]  obs,
    output logic [FAULT_W-1:0] diag,
    output logic               no_err
);

    logic [FAULT_W-1:0] inter_m;
    logic [FAULT_W-1:0] union_m;
    logic               any_miss;

    // Fold all outputs into the consistent-fault set.
    always_comb begin
        inter_m  = '1;
        union_m  = '0;
        any_miss = 1'b0;
        for (int k = 0; k < NUM_PO; k++) begin
            if (po_val[k] != obs[k]) begin
                inter_m  = inter_m & po_mask[k];
                any_miss = 1'b1;
            end else begin
                union_m = union_m | po_mask[k];
            end
        end
        diag   = any_miss ? (inter_m & ~union_m) : '0;
        no_err = ~any_miss;
    end

endmodule

// File: rtl/stuck_fault_diagnoser.sv
// Top level: deductive single stuck-at diagnosis of the fixed full-adder
// netlist. Captures pi_vec/obs_vec on start, propagates value plus fault
// mask one level per cycle, then registers the results with a done pulse.
// Assumes start is a single-cycle pulse; pulses during a run are dropped.
module stuck_fault_diagnoser
    import fdiag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NUM_PI-1:0]  pi_vec,
    input  logic [NUM_PO-1:0]  obs_vec,
    output logic               done,
    output logic [NUM_PO-1:0]  good_out,
    output logic [FAULT_W-1:0] diag_mask,
    output logic               no_error
);

    localparam logic [FAULT_W-1:0] EVEN_BITS = {NUM_GATE{2'b01}};

    logic               capture;
    logic               in_prop;
    logic [LVL_W-1:0]   eval_lvl;
    logic               fin;
    logic [NUM_PI-1:0]  pi_q;
    logic [NUM_PO-1:0]  obs_q;
    logic [NUM_SIG-1:0] sig_val;
    logic [FAULT_W-1:0] sig_mask [NUM_SIG];
    logic [NUM_PO-1:0]  po_val;
    logic [FAULT_W-1:0] po_mask [NUM_PO];
    logic [FAULT_W-1:0] diag_c;
    logic               no_err_c;

    fdiag_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .capture  (capture),
        .in_prop  (in_prop),
        .eval_lvl (eval_lvl),
        .fin      (fin)
    );

    // Capture the operands and the observation at the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pi_q  <= '0;
            obs_q <= '0;
        end else if (capture) begin
            pi_q  <= pi_vec;
            obs_q <= obs_vec;
        end
    end

    // Primary inputs: fixed value, no fault can flip them.
    for (genvar i = 0; i < NUM_PI; i++) begin : g_pi
        assign sig_val[i]  = pi_q[i];
        assign sig_mask[i] = '0;
    end

    // One cell per netlist gate, wired by the package description.
    for (genvar g = 0; g < NUM_GATE; g++) begin : g_gate
        localparam int SA = int'(gate_desc(g).src_a);
        localparam int SB = int'(gate_desc(g).src_b);
        fdiag_gate_cell #(.GATE_IDX(g)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_prop  (in_prop),
            .eval_lvl (eval_lvl),
            .a_val    (sig_val[SA]),
            .a_mask   (sig_mask[SA]),
            .b_val    (sig_val[SB]),
            .b_mask   (sig_mask[SB]),
            .out_val  (sig_val[NUM_PI+g]),
            .out_mask (sig_mask[NUM_PI+g])
        );
    end

    // Primary outputs taken from the netlist.
    for (genvar k = 0; k < NUM_PO; k++) begin : g_po
        assign po_val[k]  = sig_val[po_sig(k)];
        assign po_mask[k] = sig_mask[po_sig(k)];
    end

    fdiag_reduce u_reduce (
        .po_val  (po_val),
        .po_mask (po_mask),
        .obs     (obs_q),
        .diag    (diag_c),
        .no_err  (no_err_c)
    );

    // Register results and the done pulse at the end of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            good_out  <= '0;
            diag_mask <= '0;
            no_error  <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                good_out  <= po_val;
                diag_mask <= diag_c;
                no_error  <= no_err_c;
            end
        end
    end

    // R7: done lasts a single cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: results hold between done pulses.
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(diag_mask) && $stable(good_out) && $stable(no_error)));

    // R5: a matching observation reports an empty diagnosis.
    p_no_error_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        no_error |-> (diag_mask == '0));

    // R9: never both stuck-at faults of one gate.
    p_single_polarity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((diag_mask & (diag_mask >> 1) & EVEN_BITS) == '0));

endmodule

// File: tb/stuck_fault_diagnoser_bench.sv
// Bench: sweeps all inputs against all observed vectors and compares the
// diagnosis with a fault-injecting behavioural model of the netlist.
module stuck_fault_diagnoser_bench;

    localparam int NF  = 44;
    localparam int LAT = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    pi_vec = '0;
    logic [1:0]    obs_vec = '0;
    logic          done;
    logic [1:0]    good_out;
    logic [NF-1:0] diag_mask;
    logic          no_error;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    stuck_fault_diagnoser u_stuck_fault_diagnoser (
        .clk(clk), .rst_n(rst_n), .start(start), .pi_vec(pi_vec),
        .obs_vec(obs_vec), .done(done), .good_out(good_out),
        .diag_mask(diag_mask), .no_error(no_error)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply a fault f to gate g's output (f < 0: fault-free).
    function automatic logic fb(int g, logic v, int f);
        if (f == 2*g)     return 1'b0;
        if (f == 2*g + 1) return 1'b1;
        return v;
    endfunction

    // Behavioural full adder with one injected fault; returns {carry, sum}.
    function automatic logic [1:0] model(logic [2:0] p, int f);
        logic a, b, c;
        logic w0, w1, w2, w3, w4, w5, w6, hs, w8, w9, w10, w11, w12, w13, w14, s;
        logic w16, w17, w18, w19, w20, co;
        a = p[0]; b = p[1]; c = p[2];
        w0  = fb(0,  ~a, f);
        w1  = fb(1,  ~b, f);
        w2  = fb(2,  a & w1, f);
        w3  = fb(3,  w0 & b, f);
        w4  = fb(4,  ~w2, f);
        w5  = fb(5,  ~w3, f);
        w6  = fb(6,  w4 & w5, f);
        hs  = fb(7,  ~w6, f);
        w8  = fb(8,  ~hs, f);
        w9  = fb(9,  ~c, f);
        w10 = fb(10, hs & w9, f);
        w11 = fb(11, w8 & c, f);
        w12 = fb(12, ~w10, f);
        w13 = fb(13, ~w11, f);
        w14 = fb(14, w12 & w13, f);
        s   = fb(15, ~w14, f);
        w16 = fb(16, a & b, f);
        w17 = fb(17, hs & c, f);
        w18 = fb(18, ~w16, f);
        w19 = fb(19, ~w17, f);
        w20 = fb(20, w18 & w19, f);
        co  = fb(21, ~w20, f);
        return {co, s};
    endfunction

    // One run; optionally pokes a second start mid-run with other operands.
    task automatic run(input logic [2:0] p, input logic [1:0] o, input logic poke);
        int cnt;
        logic [1:0] good;
        logic [NF-1:0] exp;
        int sum3;
        @(negedge clk);
        pi_vec = p; obs_vec = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 3) begin
                start = 1'b1; pi_vec = ~p; obs_vec = ~o;
            end else if (poke && cnt == 4) begin
                start = 1'b0; pi_vec = p; obs_vec = o;
            end
        end
        sum3 = int'(p[0]) + int'(p[1]) + int'(p[2]);
        good = 2'(sum3);
        exp = '0;
        if (o != good)
            for (int f = 0; f < NF; f++)
                if (model(p, f) == o) exp[f] = 1'b1;
        chk(cnt == LAT, poke ? "R8 latency with mid-run start" : "R7 done latency", 64'(cnt), 64'(LAT));
        chk(good_out == good, "R2 fault-free output", 64'(good_out), 64'(good));
        chk(no_error == (o == good), "R5 no_error flag", 64'(no_error), 64'(o == good));
        chk(diag_mask == exp, (o == good) ? "R5 empty diagnosis" :
            (exp == '0) ? "R6 unreachable observation" : "R4 diagnosis mask",
            64'(diag_mask), 64'(exp));
        chk((diag_mask & (diag_mask >> 1) & {22{2'b01}}) == '0, "R9 one polarity per gate",
            64'(diag_mask), 64'(0));
        @(negedge clk);
        chk(!done, "R7 done single cycle", 64'(done), 64'(0));
        chk(diag_mask == exp, "R8 result held", 64'(diag_mask), 64'(exp));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 reset done", 64'(done), 64'(0));
        chk(diag_mask == '0, "R1 reset diag", 64'(diag_mask), 64'(0));
        chk(no_error == 1'b0, "R1 reset no_error", 64'(no_error), 64'(0));
        chk(good_out == '0, "R1 reset good_out", 64'(good_out), 64'(0));
        // R3 R4 R5 R6: every input against every observation
        for (int p = 0; p < 8; p++)
            for (int o = 0; o < 4; o++)
                run(3'(p), 2'(o), 1'b0);
        // R8: start mid-run is dropped
        run(3'b011, 2'b00, 1'b1);
        run(3'b100, 2'b00, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule